// File: doc/BRIEF.md
# Chained Receive DMA Channel

This block is one DMA channel that copies a received block from a peripheral FIFO window into a memory buffer. Software writes a chain of descriptors into memory and pulses a start input that carries the address of the first descriptor. The channel reads each descriptor in turn, moves the data it describes through a small internal beat buffer, and follows the next pointer until the chain ends. It then raises a sticky done flag and goes back to idle. A buffer of any length is handled as two linked descriptors. The first is a 32-bit body that moves `length/4` words to an aligned address. The second is an 8-bit tail that moves `length & 3` bytes. A descriptor with a count of zero is skipped.

The peripheral paces the reads. It holds a request line, and for each request the channel reads one chunk of beats from the source window. After the last beat of the chunk it gives one acknowledge pulse. Buffered beats are written to memory once the buffer level reaches a programmable watermark, and always at the end of each descriptor. Both the source and destination addresses advance by the beat width after every beat.

The controller is one state machine with these states. ST_IDLE waits for start. ST_FETCH reads the five descriptor words. ST_DECODE skips a zero count. ST_WAIT_REQ waits for the peripheral request. ST_READ reads one chunk. ST_ACK gives the acknowledge. ST_DRAIN writes the buffered beats. ST_NEXT ends the chain or follows the next pointer. The transitions are:
- IDLE→FETCH on start.
- FETCH→DECODE after the fifth word.
- DECODE→NEXT when the count is zero, otherwise DECODE→WAIT_REQ.
- WAIT_REQ→READ on request.
- READ→ACK when the chunk or the count is used up.
- ACK→DRAIN when the level has reached the watermark or the count is zero, otherwise ACK→WAIT_REQ.
- DRAIN→NEXT when the buffer is empty and the count is zero, and DRAIN→WAIT_REQ when the buffer is empty with beats left.
- NEXT→IDLE on termination, otherwise NEXT→FETCH.

Top module: `rxdma_chain`

## Requirements
- R1: After reset `chain_done`, `mem_req` and `per_ack` are 0, and they stay so until start.
- R2: A `cfg_start` pulse in idle clears `chain_done` by the next cycle and fetches five 32-bit words from `cfg_head` upward, in this order: source, destination, control A, control B, next pointer. A request is held with a stable address until granted.
- R3: Control A holds the beat count in bits [15:0] and the chunk code in bits [17:16]. A chunk is 1, 2 or 4 beats, and code 3 acts as 4. Bit 24 set means 32-bit beats and clear means 8-bit beats. Control B bit 31 is the fetch-disable (stop) bit.
- R4: A 32-bit beat reads a whole word from the source. It writes that word with byte enable 4'hF to a word-aligned destination, and both addresses then advance by 4.
- R5: An 8-bit beat reads the byte lane given by source address bits [1:0]. It writes with exactly one byte enable, on lane destination[1:0], so any destination alignment is allowed, and both addresses then advance by 1.
- R6: A descriptor whose count is zero makes no read or write and gives no acknowledge. The chain goes straight to its next pointer.
- R7: The chain ends after a descriptor whose stop bit is set or whose next pointer is zero. `chain_done` then rises and stays at 1 until the next start.
- R8: Each peripheral request gets min(chunk, remaining) reads, followed by a single-cycle `per_ack`.
- R9: After an acknowledge the buffer is drained when its level reaches the watermark, clamped to the range 1..4 with 0 read as 1. It is also drained when the descriptor's count is used up. No descriptor fetch starts with beats still buffered.
- R10: For every buffer length, including those below 4 and those that are not a multiple of 4, the body and tail pair write exactly the bytes from the FIFO in order, and nothing outside [buffer, buffer+length).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Start pulse, taken in idle |
| cfg_head | input | AW | Address of the first descriptor |
| cfg_watermark | input | WM_W | Buffer level that triggers a drain |
| chain_done | output | 1 | Sticky end-of-chain flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte lanes, for both reads and writes |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| per_req | input | 1 | Peripheral has a chunk ready |
| per_ack | output | 1 | Chunk consumed |

## Verification
The hardest case to reach from the ports is a zero-count body descriptor that is passed over on the way to an unaligned byte tail. Buffer lengths of 1 and 3 bytes placed one byte past an aligned base bring it about. Another is a drain held back by the watermark partway through a multi-chunk body. A 20-byte buffer with one-beat chunks and a watermark of 3 reaches it, and the bench counts the acknowledges seen before the first write. The stop bit is reached by building a chain whose body carries a valid next pointer but sets fetch-disable, then showing that the tail bytes stay at their guard value.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_WAIT_REQ,
        ST_READ,
        ST_ACK,
        ST_DRAIN,
        ST_NEXT
    } chain_state_e;

    localparam int DESC_WORDS = 5;
    localparam int IDX_SRC    = 0;
    localparam int IDX_DST    = 1;
    localparam int IDX_CTLA   = 2;
    localparam int IDX_CTLB   = 3;
    localparam int IDX_NEXT   = 4;

    localparam int CNT_MSB    = 15;
    localparam int CHUNK_LSB  = 16;
    localparam int WIDE_BIT   = 24;
    localparam int STOP_BIT   = 31;
endpackage

// File: rtl/rxdma_beat_fifo.sv
module rxdma_beat_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign dout  = slots[rd_ptr];
    assign full  = (level == LVL_W'(DEPTH));
    assign empty = (level == '0);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rxdma_lane_align.sv
module rxdma_lane_align (
    input  logic        wide,
    input  logic [1:0]  lane,
    input  logic [31:0] rd_word,
    input  logic [31:0] beat_in,
    output logic [31:0] beat_out,
    output logic [31:0] wr_word,
    output logic [3:0]  be
);
    logic [31:0] shifted;

    always_comb begin
        shifted  = rd_word >> {lane, 3'b000};
        beat_out = wide ? rd_word : {24'b0, shifted[7:0]};
        wr_word  = wide ? beat_in : {4{beat_in[7:0]}};
        be       = wide ? 4'hF : (4'b0001 << lane);
    end
endmodule

// File: rtl/rxdma_chain.sv
module rxdma_chain
    import rxdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int WM_W       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_start,
    input  logic [AW-1:0] cfg_head,
    input  logic [WM_W-1:0] cfg_watermark,
    output logic          chain_done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic [31:0]   mem_rdata,
    input  logic          per_req,
    output logic          per_ack
);
    localparam int LVL_W        = $clog2(FIFO_DEPTH+1);
    localparam int CHUNK_LG_MAX = $clog2(FIFO_DEPTH) - 1;
    localparam int WM_MAX       = FIFO_DEPTH / 2;
    localparam int IDX_W        = $clog2(DESC_WORDS);

    chain_state_e state, state_nx;

    logic [AW-1:0]    desc_ptr, src_addr, dst_addr, next_ptr;
    logic [IDX_W-1:0] word_idx;
    logic [CNT_W-1:0] remain, chunk_left, chunk_beats;
    logic [1:0]       chunk_code, chunk_lg;
    logic             wide, stop_bit;
    logic             terminate;
    logic [LVL_W-1:0] wm_eff;

    logic             fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [LVL_W-1:0] fifo_level;
    logic [31:0]      fifo_dout, rd_beat;
    logic             lane_wide;

    // Derived settings
    always_comb begin
        chunk_lg    = (int'(chunk_code) > CHUNK_LG_MAX) ? 2'(CHUNK_LG_MAX) : chunk_code;
        chunk_beats = CNT_W'(1) << chunk_lg;
        if (cfg_watermark == '0)               wm_eff = LVL_W'(1);
        else if (int'(cfg_watermark) > WM_MAX) wm_eff = LVL_W'(WM_MAX);
        else                                   wm_eff = LVL_W'(cfg_watermark);
        terminate   = stop_bit || (next_ptr == '0);
        lane_wide   = wide || (state == ST_FETCH);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (cfg_start) state_nx = ST_FETCH;
            ST_FETCH:    if (mem_gnt && word_idx == IDX_W'(IDX_NEXT)) state_nx = ST_DECODE;
            ST_DECODE:   state_nx = (remain == '0) ? ST_NEXT : ST_WAIT_REQ;
            ST_WAIT_REQ: if (per_req) state_nx = ST_READ;
            ST_READ:     if (mem_gnt && (chunk_left == CNT_W'(1) || remain == CNT_W'(1)))
                             state_nx = ST_ACK;
            ST_ACK:      state_nx = (remain == '0 || fifo_level >= wm_eff) ? ST_DRAIN : ST_WAIT_REQ;
            ST_DRAIN:    if (fifo_empty) state_nx = (remain == '0) ? ST_NEXT : ST_WAIT_REQ;
            ST_NEXT:     state_nx = terminate ? ST_IDLE : ST_FETCH;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = src_addr;
        per_ack   = 1'b0;
        fifo_push = 1'b0;
        fifo_pop  = 1'b0;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr + AW'({word_idx, 2'b00});
            end
            ST_READ: begin
                mem_req   = 1'b1;
                mem_addr  = src_addr;
                fifo_push = mem_gnt;
            end
            ST_ACK:   per_ack = 1'b1;
            ST_DRAIN: begin
                mem_req  = !fifo_empty;
                mem_we   = !fifo_empty;
                mem_addr = dst_addr;
                fifo_pop = !fifo_empty && mem_gnt;
            end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_ptr   <= '0;
            src_addr   <= '0;
            dst_addr   <= '0;
            next_ptr   <= '0;
            word_idx   <= '0;
            remain     <= '0;
            chunk_left <= '0;
            chunk_code <= '0;
            wide       <= 1'b0;
            stop_bit   <= 1'b0;
            chain_done <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (cfg_start) begin
                    desc_ptr   <= cfg_head;
                    word_idx   <= '0;
                    chain_done <= 1'b0;
                end
                ST_FETCH: if (mem_gnt) begin
                    word_idx <= word_idx + 1'b1;
                    unique case (int'(word_idx))
                        IDX_SRC:  src_addr <= mem_rdata[AW-1:0];
                        IDX_DST:  dst_addr <= mem_rdata[AW-1:0];
                        IDX_CTLA: begin
                            remain     <= mem_rdata[CNT_MSB:0];
                            chunk_code <= mem_rdata[CHUNK_LSB+1:CHUNK_LSB];
                            wide       <= mem_rdata[WIDE_BIT];
                        end
                        IDX_CTLB: stop_bit <= mem_rdata[STOP_BIT];
                        default:  next_ptr <= mem_rdata[AW-1:0];
                    endcase
                end
                ST_WAIT_REQ: if (per_req) chunk_left <= chunk_beats;
                ST_READ: if (mem_gnt) begin
                    src_addr   <= src_addr + (wide ? AW'(4) : AW'(1));
                    remain     <= remain - 1'b1;
                    chunk_left <= chunk_left - 1'b1;
                end
                ST_DRAIN: if (fifo_pop) dst_addr <= dst_addr + (wide ? AW'(4) : AW'(1));
                ST_NEXT: begin
                    if (terminate) chain_done <= 1'b1;
                    else begin
                        desc_ptr <= next_ptr;
                        word_idx <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    rxdma_lane_align u_align (
        .wide     (lane_wide),
        .lane     (mem_addr[1:0]),
        .rd_word  (mem_rdata),
        .beat_in  (fifo_dout),
        .beat_out (rd_beat),
        .wr_word  (mem_wdata),
        .be       (mem_be)
    );

    rxdma_beat_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (rd_beat),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
    // R4
    word_write_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && wide) |-> (mem_addr[1:0] == 2'b00 && mem_be == 4'hF));
    // R5
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !lane_wide) |-> ($countones(mem_be) == 1 && mem_be[mem_addr[1:0]]));
    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !per_ack);
    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_done && !cfg_start) |=> chain_done);
    // R9
    drained_before_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |-> fifo_empty);
endmodule

// File: tb/sim_rxdma_chain.sv
module sim_rxdma_chain;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] FIFO_WIN = 32'h8000_0000;
    localparam logic [31:0] DESC_A   = 32'h0000_0100;
    localparam logic [31:0] DESC_B   = 32'h0000_0120;
    localparam logic [31:0] BUF_BASE = 32'h0000_0400;
    localparam int NVEC = 8;
    // {length, destination offset, chunk code, watermark}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd1,  8'd1, 8'd0, 8'd1},
        {8'd3,  8'd1, 8'd1, 8'd2},
        {8'd4,  8'd0, 8'd0, 8'd1},
        {8'd5,  8'd0, 8'd1, 8'd2},
        {8'd8,  8'd0, 8'd0, 8'd4},
        {8'd8,  8'd0, 8'd2, 8'd1},
        {8'd16, 8'd0, 8'd3, 8'd1},
        {8'd20, 8'd0, 8'd0, 8'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic [31:0] cfg_head = '0;
    logic [2:0]  cfg_watermark = 3'd1;
    logic        chain_done, mem_req, mem_we, mem_gnt, per_req, per_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    logic [7:0] mem  [0:2047];
    logic [7:0] stub [0:63];
    int stub_rd = 0, stub_len = 0;
    int ack_cnt = 0, wr_cnt = 0, rd_cnt = 0, first_wr = -1;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_gnt = mem_req;
    assign per_req = (stub_rd < stub_len);

    always_comb begin
        int k;
        k = 0;
        mem_rdata = '0;
        for (int l = 0; l < 4; l++) begin
            if (mem_addr[31]) begin
                if (mem_be[l]) begin
                    mem_rdata[8*l +: 8] = stub[(stub_rd + k) & 63];
                    k++;
                end
            end else begin
                mem_rdata[8*l +: 8] = mem[{mem_addr[10:2], 2'(l)}];
            end
        end
    end

    rxdma_chain u0 (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_head(cfg_head),
        .cfg_watermark(cfg_watermark), .chain_done(chain_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .per_req(per_req), .per_ack(per_ack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put32(input logic [31:0] a, input logic [31:0] v);
        for (int b = 0; b < 4; b++) mem[a[10:0] + 11'(b)] = v[8*b +: 8];
    endtask

    function automatic int ceil_div(input int n, input int c);
        return (n + c - 1) / c;
    endfunction

    function automatic int acks_to_first_write(input int n, input int c, input int wm);
        for (int k = 1; k < 64; k++) begin
            int got;
            got = (k * c < n) ? k * c : n;
            if (got >= wm || got >= n) return k;
        end
        return -1;
    endfunction

    task automatic run_chain(input int len, input int doff, input int code,
                             input int wm, input bit stop_body);
        logic [31:0] base;
        base = BUF_BASE + 32'(doff);
        for (int a = 'h3F0; a < 'h440; a++) mem[a] = 8'hEE;
        for (int i = 0; i < 64; i++) stub[i] = 8'(8'h30 + i * 7 + len);
        put32(DESC_A,      FIFO_WIN);
        put32(DESC_A + 4,  base);
        put32(DESC_A + 8,  32'(len >> 2) | (32'(code) << 16) | 32'h0100_0000);
        put32(DESC_A + 12, stop_body ? 32'h8000_0000 : 32'h0);
        put32(DESC_A + 16, ((len & 3) != 0 || stop_body) ? DESC_B : 32'h0);
        put32(DESC_B,      FIFO_WIN);
        put32(DESC_B + 4,  base + 32'(len & ~3));
        put32(DESC_B + 8,  32'(len & 3) | (32'(code) << 16));
        put32(DESC_B + 12, 32'h8000_0000);
        put32(DESC_B + 16, 32'h0);
        stub_rd  <= 0;
        stub_len <= len;
        ack_cnt = 0; wr_cnt = 0; rd_cnt = 0; first_wr = -1;
        cfg_watermark = 3'(wm);
        cfg_head = DESC_A;
        @(negedge clk);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (chain_done) break;
            @(negedge clk);
        end
    endtask

    task automatic check_buffer(input int len, input int doff, input int good, string req);
        int bad;
        logic [31:0] base;
        base = BUF_BASE + 32'(doff);
        bad = 0;
        for (int i = 0; i < good; i++)
            if (mem[base[10:0] + 11'(i)] != stub[i]) bad++;
        check(bad == 0, req, "buffer bytes mismatched", bad, 0);
        bad = 0;
        for (int i = good; i < len + 4; i++)
            if (mem[base[10:0] + 11'(i)] != 8'hEE) bad++;
        if (mem[base[10:0] - 11'd1] != 8'hEE) bad++;
        check(bad == 0, "R10", "guard bytes overwritten", bad, 0);
    endtask

    initial begin
        fork
            forever begin
                @(posedge clk);
                if (per_ack) ack_cnt++;
                if (mem_req && mem_gnt) begin
                    if (mem_we) begin
                        if (first_wr < 0) first_wr = ack_cnt;
                        wr_cnt++;
                        for (int l = 0; l < 4; l++)
                            if (mem_be[l]) mem[{mem_addr[10:2], 2'(l)}] <= mem_wdata[8*l +: 8];
                    end else if (mem_addr[31]) begin
                        rd_cnt++;
                        stub_rd <= stub_rd + $countones(mem_be);
                    end
                end
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual 1 expected 0");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        // R1: reset state
        check(chain_done == 1'b0, "R1", "done after reset", chain_done, 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_req == 1'b0 && per_ack == 1'b0, "R1", "idle activity before start",
              mem_req | per_ack, 0);

        // Table walk: R3 R4 R5 R8 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            int len, doff, code, wm, c, w, t, n, wme;
            len = int'(VEC[v][31:24]); doff = int'(VEC[v][23:16]);
            code = int'(VEC[v][15:8]); wm = int'(VEC[v][7:0]);
            c = 1 << ((code > 2) ? 2 : code);
            wme = (wm == 0) ? 1 : ((wm > 4) ? 4 : wm);
            w = len >> 2; t = len & 3;
            n = (w > 0) ? w : t;
            run_chain(len, doff, code, wm, 1'b0);
            check(chain_done == 1'b1, "R7", "done after chain", chain_done, 1);
            check_buffer(len, doff, len, (w > 0) ? "R4" : "R5");
            check(ack_cnt == ceil_div(w, c) + ceil_div(t, c), "R8", "acknowledge count",
                  ack_cnt, ceil_div(w, c) + ceil_div(t, c));
            check(first_wr == acks_to_first_write(n, c, wme), "R9", "acks before first write",
                  first_wr, acks_to_first_write(n, c, wme));
            check(rd_cnt == w + t, "R3", "source beats read", rd_cnt, w + t);
        end

        // R6: zero-length chain, body and tail both skipped
        run_chain(0, 0, 0, 1, 1'b0);
        check(chain_done == 1'b1, "R6", "done with zero length", chain_done, 1);
        check(wr_cnt == 0 && ack_cnt == 0, "R6", "activity on zero count", wr_cnt + ack_cnt, 0);

        // R7: stop bit on body ends the chain although next pointer is valid
        run_chain(7, 0, 0, 1, 1'b1);
        check(chain_done == 1'b1, "R7", "done on stop bit", chain_done, 1);
        check_buffer(7, 0, 4, "R7");
        check(ack_cnt == 1, "R7", "acks with stop bit", ack_cnt, 1);

        // R2: start clears the sticky done flag
        repeat (5) @(negedge clk);
        check(chain_done == 1'b1, "R7", "done held in idle", chain_done, 1);
        stub_len <= 0;
        cfg_head = DESC_A;
        put32(DESC_A + 8, 32'h0100_0001);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        check(chain_done == 1'b0, "R2", "done cleared by start", chain_done, 0);
        check(mem_req == 1'b1 && mem_addr == DESC_A, "R2", "first fetch address",
              mem_addr, DESC_A);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule